// File: doc/BRIEF.md
# Synchronous Burst SRAM with Two-Strobe Address Front End

This block is a single-port synchronous SRAM of 64-bit words, with a front end that handles short bursts. Two active-low address strobes are sampled on every rising clock edge. The processor strobe always starts a read. The controller strobe can start a read or a byte-masked write, and it can also deselect the device. After an address has been taken, an active-low advance input steps a 2-bit burst counter over the two low address bits. Holding advance high makes a wait cycle, which keeps the current word.

A static order input picks the burst sequence. When it is low, the low bits count upward from the start value and wrap. When it is high, they are the start value XORed with the count. Read data is registered and appears one clock after its address is taken. Writes take the data present on the same edge as their address.

A snooze input drops the output enable at once, without waiting for a clock. While it is high, reads and writes are blocked and the array keeps its contents. The read data port and its enable stand in for a tri-state bus. While the enable is low, the data port is driven to zero.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, `rd_en` is low. Advance cycles with no strobe after reset produce no read output, because no burst is active.
- R2: A processor-strobe cycle (`proc_as_n`=0 with `chip_en_n`=0) takes `addr`. The word at that address appears on `rd_data` with `rd_en`=1 after the following clock edge, not after the strobe edge itself.
- R3: A processor-strobe cycle with `chip_en_n`=0 is a read whatever the write enables say. When both strobes are low, the processor strobe wins. A processor strobe with `chip_en_n`=1 is ignored.
- R4: A controller-strobe cycle (`ctrl_as_n`=0, `chip_en_n`=0, no winning processor strobe) takes `addr`. It writes all eight bytes when `all_we_n`=0. Otherwise it writes byte j (bits 8j+7:8j) for each `byte_we_n[j]`=0. With no enable active, it is a read.
- R5: With `order_sel`=0, each cycle with `adv_n`=0 and no strobe moves the two low address bits to start+1, start+2 and start+3, modulo 4. The upper address bits do not change. Each such cycle reads or writes by the rules of R4.
- R6: With `order_sel`=1, the low address bits of the k-th burst beat are the start value XOR k.
- R7: A cycle with `adv_n`=1 and no strobe keeps the burst address. A read wait cycle returns the same word again.
- R8: A controller strobe with `chip_en_n`=1 deselects the device. `rd_en` is low from the second edge on. Later advance cycles neither read nor write until a new address is taken.
- R9: `snooze`=1 forces `rd_en` low at once. Strobes and writes sampled while it is high have no effect, and the array is unchanged. A new strobe works after it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| snooze | input | 1 | Active-high low-power standby, array retained |
| proc_as_n | input | 1 | Processor address strobe, active low, read only |
| ctrl_as_n | input | 1 | Controller address strobe, active low |
| chip_en_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low; high means wait |
| all_we_n | input | 1 | Write all bytes, active low |
| byte_we_n | input | BYTES | Per-byte write enables, active low |
| addr | input | ADDR_W | Word address |
| wr_data | input | 8*BYTES | Write data, captured on the rising edge |
| rd_data | output | 8*BYTES | Read data, zero while rd_en is low |
| rd_en | output | 1 | Read data valid (output enable) |

## Verification
The bench aims at the read latency. A design that drives the word on the strobe edge, or two edges late, returns the wrong word or an inactive enable in the sampled cycle.

Strobe priority is tested with both strobes low and active write enables. A design that lets the controller strobe win would overwrite memory, and the read-back would show it.

Bursts are started from non-zero offsets in both orders, and wait cycles are placed in the middle of a burst. A wrong wrap or a wrong XOR gives wrong words, and an address that moves on a wait gives the next word too early.

Deselect followed by advance cycles with writes enabled, and writes issued during snooze, are both read back afterwards. A design that keeps stepping the burst after deselect, or that writes while in standby, corrupts those words.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 order_sel,
  input  logic                 snooze,
  input  logic                 proc_as_n,
  input  logic                 ctrl_as_n,
  input  logic                 chip_en_n,
  input  logic                 adv_n,
  input  logic                 all_we_n,
  input  logic [BYTES-1:0]     byte_we_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [8*BYTES-1:0]   wr_data,
  output logic [8*BYTES-1:0]   rd_data,
  output logic                 rd_en
);
  localparam int DATA_W = 8 * BYTES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              active_q, rd_q, oe_q;
  logic [DATA_W-1:0] dout_q;

  function automatic logic [1:0] beat_lo(input logic [1:0] s, input logic [1:0] c, input logic il);
    return il ? (s ^ c) : (s + c);
  endfunction

  wire proc_go = !proc_as_n && !chip_en_n;
  wire ctrl_go = !proc_go && !ctrl_as_n;
  wire desel   = ctrl_go && chip_en_n;
  wire load    = proc_go || (ctrl_go && !chip_en_n);
  wire live    = load || (active_q && !desel);

  wire [1:0]        cnt_nx  = load ? 2'd0 : (active_q && !adv_n) ? cnt_q + 2'd1 : cnt_q;
  wire [ADDR_W-1:0] base_nx = load ? addr : base_q;
  wire [ADDR_W-1:0] eff     = {base_nx[ADDR_W-1:2], beat_lo(base_nx[1:0], cnt_nx, order_sel)};
  wire [ADDR_W-1:0] cur     = {base_q[ADDR_W-1:2], beat_lo(base_q[1:0], cnt_q, order_sel)};

  wire [BYTES-1:0] wmask    = all_we_n ? ~byte_we_n : {BYTES{1'b1}};
  wire             do_write = live && !proc_go && (|wmask);

  always_ff @(posedge clk) begin
    if (!snooze && do_write) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wmask[b]) mem[eff][8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      oe_q     <= 1'b0;
      dout_q   <= '0;
    end else if (snooze) begin
      rd_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      base_q   <= base_nx;
      cnt_q    <= cnt_nx;
      active_q <= desel ? 1'b0 : (load ? 1'b1 : active_q);
      rd_q     <= live && !do_write;
      oe_q     <= rd_q;
      dout_q   <= mem[cur];
    end
  end

  assign rd_en   = oe_q && !snooze;
  assign rd_data = rd_en ? dout_q : '0;
endmodule

module sync_burst_sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              order_sel,
  input logic              snooze,
  input logic              proc_as_n,
  input logic              ctrl_as_n,
  input logic              chip_en_n,
  input logic              adv_n,
  input logic              all_we_n,
  input logic              rd_en,
  input logic [1:0]        cnt_q,
  input logic [ADDR_W-1:0] base_q,
  input logic              active_q
);
  wire no_strobe = ctrl_as_n && (proc_as_n || chip_en_n);

  AST_PROC_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_as_n && !chip_en_n && !snooze) ##1 !snooze |=> (rd_en || snooze)); // R3
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_as_n && proc_as_n && !chip_en_n && !all_we_n && !snooze) |-> ##2 !rd_en); // R4
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && no_strobe && !adv_n && !snooze && !order_sel) |=> (cnt_q == $past(cnt_q) + 2'd1)); // R5
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (no_strobe && adv_n && !snooze) |=> ($stable(cnt_q) && $stable(base_q))); // R7
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_as_n && chip_en_n && !snooze) |-> ##2 !rd_en); // R8
  AST_DESELECT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && no_strobe && !snooze) |=> !active_q); // R8
  AST_SNOOZE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |-> !rd_en); // R9
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .order_sel(order_sel), .snooze(snooze),
  .proc_as_n(proc_as_n), .ctrl_as_n(ctrl_as_n), .chip_en_n(chip_en_n),
  .adv_n(adv_n), .all_we_n(all_we_n), .rd_en(rd_en),
  .cnt_q(cnt_q), .base_q(base_q), .active_q(active_q)
);

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic order_sel, snooze, proc_as_n, ctrl_as_n, chip_en_n, adv_n, all_we_n;
  logic [NB-1:0]   byte_we_n;
  logic [AW-1:0]   addr;
  logic [8*NB-1:0] wr_data, rd_data;
  logic            rd_en;

  logic [8*NB-1:0] model_mem [1<<AW];
  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .BYTES(NB)) u_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .order_sel(order_sel), .snooze(snooze),
    .proc_as_n(proc_as_n), .ctrl_as_n(ctrl_as_n), .chip_en_n(chip_en_n),
    .adv_n(adv_n), .all_we_n(all_we_n), .byte_we_n(byte_we_n), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_en(rd_en)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    proc_as_n = 1; ctrl_as_n = 1; chip_en_n = 0; adv_n = 1;
    all_we_n = 1; byte_we_n = '1; snooze = 0;
  endtask

  function automatic logic [63:0] pat(input int a);
    return {16'hC0DE, 16'(a), 16'hBEEF, 16'(a * 3 + 1)};
  endfunction

  function automatic logic [AW-1:0] beat(input logic [AW-1:0] s, input int k, input logic il);
    logic [1:0] lo;
    lo = il ? (s[1:0] ^ 2'(k)) : (s[1:0] + 2'(k));
    return {s[AW-1:2], lo};
  endfunction

  task automatic wr_word(input logic [AW-1:0] a, input logic [63:0] d);
    ctrl_as_n = 0; chip_en_n = 0; all_we_n = 0; addr = a; wr_data = d;
    step();
    model_mem[a] = d;
    idle();
  endtask

  task automatic t_reset();
    idle();
    @(negedge clk);
    chk("R1 reset enable", 64'(rd_en), 64'd0);
    rst_n = 1;
    adv_n = 0;
    step(); step();
    chk("R1 advance after reset", 64'(rd_en), 64'd0);
    idle();
  endtask

  task automatic t_fill();
    order_sel = 0;
    for (int a = 0; a < (1 << AW); a++) wr_word(AW'(a), pat(a));
  endtask

  task automatic t_latency();
    proc_as_n = 0; addr = 6'd5;
    step();
    proc_as_n = 1;
    chk("R2 not on strobe edge", 64'(rd_en), 64'd0);
    step();
    chk("R2 enable", 64'(rd_en), 64'd1);
    chk("R2 data", rd_data, model_mem[5]);
    idle();
  endtask

  task automatic t_priority();
    proc_as_n = 0; ctrl_as_n = 0; chip_en_n = 0; all_we_n = 0; byte_we_n = '0;
    addr = 6'd9; wr_data = 64'hDEAD_DEAD_DEAD_DEAD;
    step();
    idle();
    step();
    chk("R3 both strobes read", rd_data, model_mem[9]);
    proc_as_n = 0; chip_en_n = 1; addr = 6'd20;
    step(); step();
    chk("R3 strobe ignored when disabled", rd_data, model_mem[9]);
    idle();
    wr_word(6'd0, model_mem[0]);
    proc_as_n = 0; addr = 6'd9;
    step(); idle(); step();
    chk("R3 no write on processor strobe", rd_data, model_mem[9]);
  endtask

  task automatic t_bytes();
    logic [63:0] d;
    d = 64'h1111_2222_3333_4444;
    ctrl_as_n = 0; all_we_n = 1; byte_we_n = 8'b1111_0101; addr = 6'd30; wr_data = d;
    step();
    for (int b = 0; b < NB; b++)
      if (b == 1 || b == 3) model_mem[30][8*b +: 8] = d[8*b +: 8];
    byte_we_n = '1;
    step();
    idle();
    step();
    chk("R4 byte write and controller read enable", 64'(rd_en), 64'd1);
    chk("R4 byte write data", rd_data, model_mem[30]);
  endtask

  task automatic rd_burst(input logic [AW-1:0] s, input logic il, input string req);
    order_sel = il; proc_as_n = 0; addr = s;
    step();
    proc_as_n = 1;
    for (int i = 1; i < 4; i++) begin
      adv_n = 0;
      step();
      chk(req, rd_data, model_mem[beat(s, i - 1, il)]);
    end
    adv_n = 1;
    step();
    chk(req, rd_data, model_mem[beat(s, 3, il)]);
    idle();
  endtask

  task automatic wr_burst(input logic [AW-1:0] s, input logic il);
    order_sel = il; ctrl_as_n = 0; all_we_n = 0; addr = s; wr_data = 64'hA000 + 64'(s);
    step();
    model_mem[s] = wr_data;
    ctrl_as_n = 1;
    for (int i = 1; i < 4; i++) begin
      adv_n = 0; wr_data = 64'hB0B0_0000 + 64'(i);
      step();
      model_mem[beat(s, i, il)] = wr_data;
    end
    idle();
  endtask

  task automatic t_linear();
    rd_burst(6'h0A, 1'b0, "R5 linear read");
    wr_burst(6'h21, 1'b0);
    rd_burst(6'h20, 1'b0, "R5 linear write");
  endtask

  task automatic t_interleave();
    rd_burst(6'h15, 1'b1, "R6 interleaved read");
    wr_burst(6'h32, 1'b1);
    rd_burst(6'h30, 1'b0, "R6 interleaved write");
    order_sel = 0;
  endtask

  task automatic t_wait();
    order_sel = 0; proc_as_n = 0; addr = 6'h2C;
    step(); proc_as_n = 1;
    adv_n = 0; step(); chk("R7 beat0", rd_data, model_mem[6'h2C]);
    adv_n = 1; step(); chk("R7 beat1", rd_data, model_mem[6'h2D]);
    adv_n = 1; step(); chk("R7 wait repeat", rd_data, model_mem[6'h2D]);
    adv_n = 0; step(); chk("R7 wait repeat 2", rd_data, model_mem[6'h2D]);
    adv_n = 1; step(); chk("R7 beat2", rd_data, model_mem[6'h2E]);
    idle();
  endtask

  task automatic t_deselect();
    proc_as_n = 0; addr = 6'h2C;
    step(); proc_as_n = 1;
    ctrl_as_n = 0; chip_en_n = 1;
    step();
    idle(); adv_n = 0; all_we_n = 0; wr_data = 64'hBAD0_BAD0_BAD0_BAD0;
    step();
    chk("R8 deselect enable", 64'(rd_en), 64'd0);
    step();
    chk("R8 advance after deselect", 64'(rd_en), 64'd0);
    idle();
    rd_burst(6'h2C, 1'b0, "R8 no write after deselect");
  endtask

  task automatic t_snooze();
    proc_as_n = 0; addr = 6'd7;
    step(); proc_as_n = 1;
    step();
    chk("R9 before snooze", 64'(rd_en), 64'd1);
    snooze = 1;
    #1;
    chk("R9 immediate off", 64'(rd_en), 64'd0);
    ctrl_as_n = 0; all_we_n = 0; addr = 6'd7; wr_data = 64'hFFFF_0000_FFFF_0000;
    step(); step();
    chk("R9 off during snooze", 64'(rd_en), 64'd0);
    idle();
    proc_as_n = 0; addr = 6'd7;
    step(); proc_as_n = 1; step();
    chk("R9 data retained", rd_data, model_mem[7]);
    chk("R9 resumes", 64'(rd_en), 64'd1);
    idle();
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    order_sel = 0; addr = '0; wr_data = '0;
    idle();
    t_reset();
    t_fill();
    t_latency();
    t_priority();
    t_bytes();
    t_linear();
    t_interleave();
    t_wait();
    t_deselect();
    t_snooze();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule